// File: doc/BRIEF.md
# Three-Queue DMA Scheduling Arbiter

This block decides which of three descriptor queues owns a shared DMA engine next. It also serves two special transfer sources that outrank every queue: delayed-interrupt transfers and descriptor fetches that move descriptors from system memory into a queue. The engine reports its progress with end-of-burst, end-of-descriptor and end-of-chain pulses. The arbiter answers with a registered one-hot grant and a grant-valid flag.

Queue 0 normally has strict priority. Queues 1 and 2 share a round-robin rotation. An all-equal setting rotates among all three queues instead. A two-bit setting chooses how long a queue keeps its grant: one burst, one descriptor, or a whole descriptor chain. The special sources are re-arbitrated at every burst boundary, whatever that setting is. When a special source interrupts a queue before its boundary, the queue gets the engine back afterwards. A per-queue halt flag, raised after an error, takes a queue out of arbitration.

Top module: `dma_queue_sched`

## Requirements
- R1: `grant` is one-hot or zero. Bits 0 to 2 are queues 0 to 2, bit 3 is the delayed-interrupt source and bit 4 is the descriptor-fetch source. `grantValid` is high exactly when a `grant` bit is set.
- R2: With `rrAll` low, an eligible queue 0 wins every queue arbitration over queues 1 and 2.
- R3: Queues 1 and 2 alternate, and queue 1 comes first after reset. The rotation pointer moves to a queue only when that queue's grant ends at its boundary.
- R4: The `arbPoint` setting selects the boundary that ends a queue grant. A value of 0 or 3 means `burstDone`. A value of 1 means `descDone` together with `burstDone`. A value of 2 means `chainDone` together with `burstDone`. A pulse that the current setting does not select leaves the grant unchanged.
- R5: With `rrAll` high, queues 0, 1 and 2 rotate with equal priority, and queue 0 comes first after reset.
- R6: With `arbPoint` = 2, a queue is eligible for a new grant only when its 6-bit descriptor index (`qDescIdx` bits 6q+5..6q) is zero, which marks the head of a chain.
- R7: At every decision, a special request wins over the queues. A special grant lasts one burst. A queue that was interrupted before its boundary gets its grant back once no special request remains.
- R8: When `intReq` and `fetchReq` are both high, the delayed-interrupt source is granted.
- R9: A queue whose `qHalt` bit is set is never given a new grant. If the queue currently granted becomes halted, its grant is withdrawn one clock later and the arbiter chooses again.
- R10: With no eligible queue and no special request, `grantValid` is low. From idle, a grant appears one clock after a request is presented.
- R11: A grant changes only on the clock edge that follows a `burstDone` or the halting of the granted queue. At all other times it holds, even if a higher-priority queue becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| qReady | input | 3 | Current descriptor of each queue is ready |
| qHalt | input | 3 | Queue halted after an error |
| qDescIdx | input | 18 | Position of each queue's current descriptor in its chain, 6 bits per queue |
| burstDone | input | 1 | Engine finished a request-length burst |
| descDone | input | 1 | Engine finished a descriptor (qualified by burstDone) |
| chainDone | input | 1 | Engine finished a descriptor chain (qualified by burstDone) |
| intReq | input | 1 | Delayed-interrupt transfer request |
| fetchReq | input | 1 | Descriptor-fetch request |
| arbPoint | input | 2 | Queue boundary selection |
| rrAll | input | 1 | All three queues at equal priority |
| grant | output | 5 | One-hot grant |
| grantValid | output | 1 | A grant is active |

## Verification
Two kinds of event can fall in the same cycle. A queue can reach its boundary, which ends its session and moves the rotation pointer, in the same `burstDone` cycle in which a special source takes the engine. The bench arranges this by raising `intReq` together with a boundary pulse. It then expects the interrupt grant first and, one burst later, the other queue, not the previously interrupted one. In the same way, a halt that arrives while a grant is held is checked to hand the engine to the next eligible queue one clock later. An exhaustive sweep over ready, halt and special-request patterns from idle judges each first grant against a priority computed arithmetically in the bench.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
  localparam int NQ = 3;
  localparam int QW = $clog2(NQ);
  localparam int GW = NQ + 2;
  localparam int G_INT = NQ;
  localparam int G_FETCH = NQ + 1;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_INT   = 3'd1,
    SEL_FETCH = 3'd2,
    SEL_HOLD  = 3'd3,
    SEL_NEW   = 3'd4
  } sel_e;

  typedef struct packed {
    logic decide;
    sel_e sel;
    logic advPtr;
  } strb_t;
endpackage

// File: rtl/dqs_dpath.sv
module dqs_dpath
  import dqs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NQ-1:0]       qReady,
  input  logic [NQ-1:0]       qHalt,
  input  logic [NQ*IDX_W-1:0] qDescIdx,
  input  logic                chainMode,
  input  logic                rrAll,
  input  strb_t               strb,
  output logic                anyElig,
  output logic [QW-1:0]       pickQ,
  output logic [QW-1:0]       sessQ
);
  logic [NQ-1:0] elig;
  logic [QW-1:0] ptrR;
  logic [QW-1:0] ptrEff;
  logic          found;
  int            cand;

  for (genvar i = 0; i < NQ; i++) begin : g_elig
    logic atHead;
    assign atHead  = (qDescIdx[i*IDX_W +: IDX_W] == '0);
    assign elig[i] = qReady[i] & ~qHalt[i] & (~chainMode | atHead);
  end

  assign anyElig = |elig;
  assign ptrEff  = strb.advPtr ? sessQ : ptrR;

  always_comb begin
    pickQ = '0;
    found = 1'b0;
    cand  = 0;
    if (!rrAll && elig[0]) begin
      pickQ = '0;
      found = 1'b1;
    end
    for (int k = 1; k <= NQ; k++) begin
      cand = int'(ptrEff) + k;
      if (cand >= NQ) cand = cand - NQ;
      if (!found && elig[cand[QW-1:0]] && (rrAll || cand != 0)) begin
        pickQ = cand[QW-1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrR  <= QW'(NQ - 1);
      sessQ <= '0;
    end else begin
      if (strb.advPtr) ptrR <= sessQ;
      if (strb.decide && strb.sel == SEL_NEW) sessQ <= pickQ;
    end
  end

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advPtr |=> $stable(ptrR));

  // R9
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyElig |-> elig[pickQ]);
endmodule

// File: rtl/dqs_ctrl.sv
module dqs_ctrl
  import dqs_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          burstDone,
  input  logic          descDone,
  input  logic          chainDone,
  input  logic          intReq,
  input  logic          fetchReq,
  input  logic [1:0]    arbPoint,
  input  logic [NQ-1:0] qHalt,
  input  logic          anyElig,
  input  logic [QW-1:0] pickQ,
  input  logic [QW-1:0] sessQ,
  output strb_t         strb,
  output logic [GW-1:0] grant,
  output logic          grantValid
);
  logic [GW-1:0] grantR;
  logic [GW-1:0] grantNext;
  logic          sessV;
  logic          qGranted;
  logic          sessHalt;
  logic          bSel;
  logic          qBoundary;
  logic          haltDrop;
  logic          endSess;

  assign qGranted   = |grantR[NQ-1:0];
  assign sessHalt   = sessV & qHalt[sessQ];
  assign haltDrop   = qGranted & sessHalt;
  assign grant      = grantR;
  assign grantValid = |grantR;

  always_comb begin
    unique case (arbPoint)
      2'd1:    bSel = descDone;
      2'd2:    bSel = chainDone;
      default: bSel = 1'b1;
    endcase
  end

  assign qBoundary = qGranted & burstDone & bSel;
  assign endSess   = sessV & (qBoundary | sessHalt);

  always_comb begin
    strb.decide = ~grantValid | burstDone | haltDrop;
    strb.advPtr = qBoundary;
    if (intReq)                 strb.sel = SEL_INT;
    else if (fetchReq)          strb.sel = SEL_FETCH;
    else if (sessV && !endSess) strb.sel = SEL_HOLD;
    else if (anyElig)           strb.sel = SEL_NEW;
    else                        strb.sel = SEL_NONE;
  end

  always_comb begin
    grantNext = grantR;
    if (strb.decide) begin
      grantNext = '0;
      unique case (strb.sel)
        SEL_INT:   grantNext[G_INT] = 1'b1;
        SEL_FETCH: grantNext[G_FETCH] = 1'b1;
        SEL_HOLD:  grantNext[sessQ] = 1'b1;
        SEL_NEW:   grantNext[pickQ] = 1'b1;
        default:   grantNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantR <= '0;
      sessV  <= 1'b0;
    end else begin
      grantR <= grantNext;
      if (strb.decide) begin
        if (strb.sel == SEL_NEW) sessV <= 1'b1;
        else if (endSess)        sessV <= 1'b0;
      end
    end
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantR));

  // R7
  special_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!grantValid || burstDone) && intReq) |=> grantR[G_INT]);

  // R8
  int_over_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantR[G_FETCH]) |-> !$past(intReq));

  // R11
  grant_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !burstDone && !haltDrop) |=> $stable(grantR));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && !intReq && !fetchReq && !anyElig) |=> !grantValid);

  for (genvar i = 0; i < NQ; i++) begin : g_haltChk
    // R9
    halt_block_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grantR[i]) |-> !$past(qHalt[i]));
  end
endmodule

// File: rtl/dma_queue_sched.sv
module dma_queue_sched
  import dqs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NQ-1:0]       qReady,
  input  logic [NQ-1:0]       qHalt,
  input  logic [NQ*IDX_W-1:0] qDescIdx,
  input  logic                burstDone,
  input  logic                descDone,
  input  logic                chainDone,
  input  logic                intReq,
  input  logic                fetchReq,
  input  logic [1:0]          arbPoint,
  input  logic                rrAll,
  output logic [GW-1:0]       grant,
  output logic                grantValid
);
  strb_t         strb;
  logic          anyElig;
  logic [QW-1:0] pickQ;
  logic [QW-1:0] sessQ;
  logic          chainMode;

  assign chainMode = (arbPoint == 2'd2);

  dqs_dpath #(.IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rstN(rstN), .qReady(qReady), .qHalt(qHalt),
    .qDescIdx(qDescIdx), .chainMode(chainMode), .rrAll(rrAll),
    .strb(strb), .anyElig(anyElig), .pickQ(pickQ), .sessQ(sessQ)
  );

  dqs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .burstDone(burstDone), .descDone(descDone),
    .chainDone(chainDone), .intReq(intReq), .fetchReq(fetchReq),
    .arbPoint(arbPoint), .qHalt(qHalt), .anyElig(anyElig), .pickQ(pickQ),
    .sessQ(sessQ), .strb(strb), .grant(grant), .grantValid(grantValid)
  );
endmodule

// File: tb/dma_queue_sched_tb.sv
`timescale 1ns/1ps
module dma_queue_sched_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  qReady = '0;
  logic [2:0]  qHalt = '0;
  logic [17:0] qDescIdx = '0;
  logic        burstDone = 1'b0, descDone = 1'b0, chainDone = 1'b0;
  logic        intReq = 1'b0, fetchReq = 1'b0;
  logic [1:0]  arbPoint = '0;
  logic        rrAll = 1'b0;
  logic [4:0]  grant;
  logic        grantValid;
  int          nChecks = 0;
  int          nErr = 0;
  bit          finished = 1'b0;

  localparam logic [4:0] G0 = 5'b00001, G1 = 5'b00010, G2 = 5'b00100;
  localparam logic [4:0] GI = 5'b01000, GF = 5'b10000, GN = 5'b00000;

  always #2.5 clk = ~clk;

  dma_queue_sched dut_i (
    .clk(clk), .rstN(rstN), .qReady(qReady), .qHalt(qHalt), .qDescIdx(qDescIdx),
    .burstDone(burstDone), .descDone(descDone), .chainDone(chainDone),
    .intReq(intReq), .fetchReq(fetchReq), .arbPoint(arbPoint), .rrAll(rrAll),
    .grant(grant), .grantValid(grantValid)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    nChecks++;
    if (grant !== exp || grantValid !== (|exp)) begin
      nErr++;
      $display("FAIL %s grant=%b valid=%b expected grant=%b valid=%b",
               req, grant, grantValid, exp, |exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    qReady = '0; qHalt = '0; qDescIdx = '0;
    burstDone = 1'b0; descDone = 1'b0; chainDone = 1'b0;
    intReq = 1'b0; fetchReq = 1'b0; arbPoint = '0; rrAll = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  task automatic pulse(input logic b, input logic d, input logic c);
    burstDone = b; descDone = d; chainDone = c;
    tick();
    burstDone = 1'b0; descDone = 1'b0; chainDone = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 reset", GN);

    // Sweep from idle: all ready/halt/special patterns, both priority modes
    for (int rr = 0; rr < 2; rr++) begin
      for (int r = 0; r < 8; r++) begin
        for (int h = 0; h < 8; h++) begin
          for (int s = 0; s < 4; s++) begin
            logic [2:0] e;
            logic [4:0] exp;
            string tag;
            doReset();
            rrAll = rr[0]; qReady = r[2:0]; qHalt = h[2:0];
            intReq = s[0]; fetchReq = s[1];
            tick();
            e = r[2:0] & ~h[2:0];
            if (s[0])      begin exp = GI; tag = "R8 sweep"; end
            else if (s[1]) begin exp = GF; tag = "R7 sweep"; end
            else begin
              exp = {2'b00, e & (~e + 3'd1)};
              if (e == 0)       tag = "R10 sweep";
              else if (h != 0)  tag = "R9 sweep";
              else if (rr != 0) tag = "R5 sweep";
              else              tag = "R2 sweep";
            end
            chk(tag, exp);
          end
        end
      end
    end

    // R2 strict priority of queue 0 across bursts
    doReset(); qReady = 3'b111; tick();
    chk("R2 first", G0);
    pulse(1, 0, 0); chk("R2 burst1", G0);
    pulse(1, 0, 0); chk("R2 burst2", G0);

    // R3 alternation of queues 1 and 2
    doReset(); qReady = 3'b110; tick();
    chk("R3 first q1", G1);
    pulse(1, 0, 0); chk("R3 then q2", G2);
    pulse(1, 0, 0); chk("R3 back q1", G1);

    // R5 all-equal rotation
    doReset(); rrAll = 1'b1; qReady = 3'b111; tick();
    chk("R5 q0", G0);
    pulse(1, 0, 0); chk("R5 q1", G1);
    pulse(1, 0, 0); chk("R5 q2", G2);
    pulse(1, 0, 0); chk("R5 wrap q0", G0);

    // R4 descriptor boundary
    doReset(); arbPoint = 2'd1; qReady = 3'b110; tick();
    chk("R4 desc first", G1);
    pulse(1, 0, 0); chk("R4 burst only holds", G1);
    pulse(1, 1, 0); chk("R4 desc boundary", G2);
    pulse(1, 0, 1); chk("R4 chain pulse ignored in desc mode", G2);

    // R4 setting 3 behaves as burst
    doReset(); arbPoint = 2'd3; qReady = 3'b110; tick();
    chk("R4 mode3 first", G1);
    pulse(1, 0, 0); chk("R4 mode3 burst boundary", G2);

    // R6 chain mode and head index
    doReset(); arbPoint = 2'd2; qReady = 3'b011;
    qDescIdx[5:0] = 6'd5; qDescIdx[11:6] = 6'd0; tick();
    chk("R6 only head queue eligible", G1);
    pulse(1, 1, 0); chk("R6 desc end holds chain", G1);
    qDescIdx[11:6] = 6'd3; qDescIdx[5:0] = 6'd0;
    pulse(1, 0, 1); chk("R6 chain end picks head q0", G0);

    // R7 pre-emption and return to held queue
    doReset(); arbPoint = 2'd1; qReady = 3'b110; tick();
    chk("R7 start q1", G1);
    intReq = 1'b1;
    pulse(1, 0, 0); chk("R7 int preempts", GI);
    intReq = 1'b0; fetchReq = 1'b1;
    pulse(1, 0, 0); chk("R7 fetch next", GF);
    fetchReq = 1'b0;
    pulse(1, 0, 0); chk("R7 returns to q1", G1);
    pulse(1, 1, 0); chk("R3 q2 after q1 boundary", G2);

    // R7 with R3: special arrives in the boundary cycle
    doReset(); qReady = 3'b110; tick();
    chk("R7 boundary start", G1);
    intReq = 1'b1;
    pulse(1, 0, 0); chk("R7 int at boundary", GI);
    intReq = 1'b0;
    pulse(1, 0, 0); chk("R3 pointer moved at boundary", G2);

    // R8 both specials while a queue is held
    doReset(); arbPoint = 2'd1; qReady = 3'b001; tick();
    intReq = 1'b1; fetchReq = 1'b1;
    pulse(1, 0, 0); chk("R8 int wins", GI);
    intReq = 1'b0;
    pulse(1, 0, 0); chk("R8 fetch after", GF);
    fetchReq = 1'b0;
    pulse(1, 0, 0); chk("R7 resume q0", G0);

    // R9 halt of the granted queue
    doReset(); arbPoint = 2'd1; qReady = 3'b110; tick();
    chk("R9 start q1", G1);
    qHalt = 3'b010; tick();
    chk("R9 halted grant dropped", G2);
    qHalt = 3'b000;
    pulse(1, 1, 0); chk("R9 rotation after drop", G1);
    qReady = 3'b010; qHalt = 3'b010;
    pulse(1, 1, 0); chk("R9 halted only queue idle", GN);

    // R10 idle and one-clock latency
    doReset(); tick(); tick();
    chk("R10 idle", GN);
    qReady = 3'b100;
    chk("R10 not before clock", GN);
    tick(); chk("R10 grant after one clock", G2);
    qReady = 3'b000;
    pulse(1, 0, 0); chk("R10 idle after boundary", GN);

    // R11 grant holds between boundaries
    doReset(); arbPoint = 2'd1; qReady = 3'b110; tick();
    chk("R11 start", G1);
    qReady = 3'b111;
    tick(); tick(); tick();
    chk("R11 q0 does not preempt held grant", G1);
    burstDone = 1'b1; descDone = 1'b1;
    #1; chk("R11 unchanged before edge", G1);
    tick();
    burstDone = 1'b0; descDone = 1'b0;
    chk("R11 changes after boundary", G0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule